// File: doc/BRIEF.md
# Shift and Rotate Execution Unit

This unit executes the whole family of integer shift and rotate operations on byte, word and doubleword operands: plain left and right shifts, a sign-keeping right shift, rotates with and without the carry flag in the loop, and double-width shifts that pull fresh bits from a second operand. A request carries an opcode, the operand size, the destination value, a source value for the double-width shifts, a shift count and the incoming carry flag. The full multi-bit shift is formed in one pass of combinational logic and captured in an output register.

Requests and results use a valid/ready handshake on each side. An accepted request produces its result and its updated carry flag on the next cycle. A result that is not taken stays on the outputs. A new request can be accepted in the same cycle that the previous result is taken, so the unit sustains one operation per cycle.

Top module: `shrot_unit`

## Requirements
- R1: A request is accepted on a rising edge with in_valid and in_ready both high. The next cycle shows out_valid high with that request's result. in_ready is high whenever no result is held or the held result is being taken. After reset, out_valid is low and in_ready is high.
- R2: While out_valid is high and out_ready is low, out_valid, out_res and out_cf all hold their values.
- R3: Only the low 5 bits of in_cnt are used. When those 5 bits are zero, out_res equals in_dst truncated to the operand size and out_cf equals in_cf, whatever the opcode.
- R4: Opcode 0 (left shift) moves zeros in at bit 0. out_cf is the last bit moved out past the top of the operand, and it is 0 once the count exceeds the width.
- R5: Opcode 1 (logical right shift) moves zeros in at the top bit. out_cf is the last bit moved out of bit 0.
- R6: Opcode 2 (arithmetic right shift) keeps the sign bit and copies it downward, so byte 8'h80 shifted by 1 gives 8'hC0 with out_cf 0. For counts at or above the width, every bit and out_cf equal the sign.
- R7: Opcode 3 rotates left and opcode 4 rotates right. out_cf equals the bit that last wrapped around, which is result bit 0 for the left rotate and the top bit for the right rotate. A count equal to the width returns the original value.
- R8: Opcodes 5 and 6 rotate left and right through carry, treating {carry, operand} as a (width+1)-bit ring. A count above width+1 acts as the count modulo width+1.
- R9: Opcode 7 shifts the destination left and fills from the source's high bits, as if shifting the pair {dst, src}. dst 32'h00003456, src 32'h10000000 and count 4 give 32'h00034561. out_cf is the last bit moved out of the destination.
- R10: Opcode 8 shifts the destination right and fills from the source's low bits, as if shifting the pair {src, dst}. out_cf is the last bit moved out of bit 0 of the destination.
- R11: in_size 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits. The bits of out_res above the size are 0. Opcodes 7 and 8 at size 0, and opcodes 9 to 15, return the truncated destination with the carry unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request this cycle |
| in_op | input | 4 | Operation code |
| in_size | input | 2 | Operand size select |
| in_dst | input | 32 | Destination operand |
| in_src | input | 32 | Fill operand for double-width shifts |
| in_cnt | input | 8 | Shift count (low 5 bits used) |
| in_cf | input | 1 | Incoming carry flag |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_res | output | 32 | Result, zero-extended above the size |
| out_cf | output | 1 | Updated carry flag |

## Verification
The properties assume that request fields are sampled only at the acceptance edge, so they relate outputs one cycle later to the inputs seen on that edge. They also assume that reset is applied before the first request. The stimulus keeps every request field steady until the request is accepted, and it releases reset before driving any traffic. The consumer's ready is randomised, so both stalled and back-to-back results occur. The counts cover zero, exactly the width, above the width, and the masked upper bits, for every size and opcode.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
  localparam int DATA_W  = 32;
  localparam int CNT_W   = 8;
  localparam int CMASK_W = 5;
  localparam int OP_W    = 4;
  localparam int SZ_W    = 2;

  localparam logic [OP_W-1:0] OP_SHL  = 4'd0;
  localparam logic [OP_W-1:0] OP_SHR  = 4'd1;
  localparam logic [OP_W-1:0] OP_SAR  = 4'd2;
  localparam logic [OP_W-1:0] OP_ROL  = 4'd3;
  localparam logic [OP_W-1:0] OP_ROR  = 4'd4;
  localparam logic [OP_W-1:0] OP_RCL  = 4'd5;
  localparam logic [OP_W-1:0] OP_RCR  = 4'd6;
  localparam logic [OP_W-1:0] OP_SHLD = 4'd7;
  localparam logic [OP_W-1:0] OP_SHRD = 4'd8;

  localparam logic [SZ_W-1:0] SZ_B = 2'd0;
  localparam logic [SZ_W-1:0] SZ_H = 2'd1;

  typedef logic [DATA_W-1:0]  word_t;
  typedef logic [CMASK_W-1:0] amt_t;

  typedef struct packed {
    word_t res;
    logic  cf;
  } shrot_out_t;

  function automatic int unsigned width_of(logic [SZ_W-1:0] sz);
    case (sz)
      2'd0:    return 8;
      2'd1:    return 16;
      default: return 32;
    endcase
  endfunction

  function automatic word_t size_mask(logic [SZ_W-1:0] sz);
    case (sz)
      2'd0:    return DATA_W'(8'hFF);
      2'd1:    return DATA_W'(16'hFFFF);
      default: return {DATA_W{1'b1}};
    endcase
  endfunction

  function automatic shrot_out_t f_shl(word_t d, int unsigned w, amt_t c);
    logic [2*DATA_W-1:0] t;
    shrot_out_t o;
    t     = {{DATA_W{1'b0}}, d} << c;
    o.res = DATA_W'(t);
    o.cf  = 1'(t >> w);
    return o;
  endfunction

  function automatic shrot_out_t f_shr(word_t d, amt_t c);
    logic [2*DATA_W-1:0] t;
    shrot_out_t o;
    t     = {d, {DATA_W{1'b0}}} >> c;
    o.res = DATA_W'(t >> DATA_W);
    o.cf  = 1'(t >> (DATA_W - 1));
    return o;
  endfunction

  function automatic shrot_out_t f_sar(word_t d, int unsigned w, word_t m, amt_t c);
    logic signed [2*DATA_W-1:0] t;
    word_t sx;
    shrot_out_t o;
    sx    = 1'(d >> (w - 1)) ? (d | ~m) : d;
    t     = {sx, {DATA_W{1'b0}}};
    t     = t >>> c;
    o.res = DATA_W'(t >> DATA_W);
    o.cf  = 1'(t >> (DATA_W - 1));
    return o;
  endfunction

  function automatic shrot_out_t f_rot(word_t d, int unsigned w, amt_t r, logic left);
    word_t t;
    shrot_out_t o;
    if (left) t = (d << r) | (d >> (w - r));
    else      t = (d >> r) | (d << (w - r));
    o.res = t;
    o.cf  = left ? t[0] : 1'(t >> (w - 1));
    return o;
  endfunction

  function automatic shrot_out_t f_rcx(word_t d, logic cin, int unsigned w, amt_t r, logic left);
    logic [2*DATA_W-1:0] v, t;
    shrot_out_t o;
    v = ((2*DATA_W)'(cin) << w) | (2*DATA_W)'(d);
    if (left) t = (v << r) | (v >> (w + 1 - r));
    else      t = (v >> r) | (v << (w + 1 - r));
    o.res = DATA_W'(t);
    o.cf  = 1'(t >> w);
    return o;
  endfunction

  function automatic shrot_out_t f_dbl(word_t d, word_t s, int unsigned w, amt_t c, logic left);
    logic [3*DATA_W-1:0] cat, sh;
    shrot_out_t o;
    if (left) begin
      cat   = ((3*DATA_W)'(d) << w) | (3*DATA_W)'(s);
      sh    = cat << c;
      o.res = DATA_W'(sh >> w);
      o.cf  = 1'(sh >> (2 * w));
    end else begin
      cat   = ((3*DATA_W)'(s) << w) | (3*DATA_W)'(d);
      sh    = (cat << 1) >> c;
      o.res = DATA_W'(sh >> 1);
      o.cf  = sh[0];
    end
    return o;
  endfunction
endpackage

// File: rtl/shrot_count_prep.sv
module shrot_count_prep
  import shrot_pkg::*;
#(
  parameter int CNT_WIDTH  = CNT_W,
  parameter int MASK_WIDTH = CMASK_W
) (
  input  logic [CNT_WIDTH-1:0]  cnt,
  input  logic [SZ_W-1:0]       size,
  output logic [MASK_WIDTH-1:0] cnt_eff,
  output logic                  cnt_zero,
  output logic [MASK_WIDTH-1:0] rot_amt,
  output logic [MASK_WIDTH-1:0] rcx_amt
);
  logic unused_cnt_hi;
  assign unused_cnt_hi = ^cnt[CNT_WIDTH-1:MASK_WIDTH];

  // R3: only the low bits of the count take part
  assign cnt_eff  = cnt[MASK_WIDTH-1:0];
  assign cnt_zero = (cnt_eff == '0);

  // R7: plain rotate amount is the count modulo the width
  always_comb begin
    case (size)
      2'd0:    rot_amt = {2'b00, cnt_eff[2:0]};
      2'd1:    rot_amt = {1'b0, cnt_eff[3:0]};
      default: rot_amt = cnt_eff;
    endcase
  end

  // R8: through-carry amount is the count modulo width+1
  always_comb begin
    case (size)
      2'd0: begin
        if      (cnt_eff >= 5'd27) rcx_amt = cnt_eff - 5'd27;
        else if (cnt_eff >= 5'd18) rcx_amt = cnt_eff - 5'd18;
        else if (cnt_eff >= 5'd9)  rcx_amt = cnt_eff - 5'd9;
        else                       rcx_amt = cnt_eff;
      end
      2'd1:    rcx_amt = (cnt_eff >= 5'd17) ? cnt_eff - 5'd17 : cnt_eff;
      default: rcx_amt = cnt_eff;
    endcase
  end
endmodule

// File: rtl/shrot_datapath.sv
module shrot_datapath
  import shrot_pkg::*;
(
  input  logic [OP_W-1:0]    op,
  input  logic [SZ_W-1:0]    size,
  input  word_t              dst,
  input  word_t              src,
  input  logic               cf_in,
  input  amt_t               cnt_eff,
  input  logic               cnt_zero,
  input  amt_t               rot_amt,
  input  amt_t               rcx_amt,
  output word_t              res,
  output logic               cf_out,
  output logic               passthru
);
  int unsigned w;
  word_t       m, d, s;
  shrot_out_t  r;
  logic        dbl_op;

  assign w      = width_of(size);
  assign m      = size_mask(size);
  assign d      = dst & m;
  assign s      = src & m;
  assign dbl_op = (op == OP_SHLD) || (op == OP_SHRD);

  // R3, R11: cases that leave the operand untouched
  assign passthru = cnt_zero || (op > OP_SHRD) || (dbl_op && size == SZ_B);

  always_comb begin
    r = '{res: d, cf: cf_in};
    if (!passthru) begin
      case (op)
        OP_SHL:  r = f_shl(d, w, cnt_eff);          // R4
        OP_SHR:  r = f_shr(d, cnt_eff);             // R5
        OP_SAR:  r = f_sar(d, w, m, cnt_eff);       // R6
        OP_ROL:  r = f_rot(d, w, rot_amt, 1'b1);    // R7
        OP_ROR:  r = f_rot(d, w, rot_amt, 1'b0);    // R7
        OP_RCL:  r = f_rcx(d, cf_in, w, rcx_amt, 1'b1); // R8
        OP_RCR:  r = f_rcx(d, cf_in, w, rcx_amt, 1'b0); // R8
        OP_SHLD: r = f_dbl(d, s, w, cnt_eff, 1'b1); // R9
        OP_SHRD: r = f_dbl(d, s, w, cnt_eff, 1'b0); // R10
        default: r = '{res: d, cf: cf_in};
      endcase
    end
  end

  // R11: nothing above the operand size leaves the unit
  assign res    = r.res & m;
  assign cf_out = r.cf;
endmodule

// File: rtl/shrot_out_stage.sv
module shrot_out_stage
  import shrot_pkg::*;
#(
  parameter int WIDTH = DATA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] nxt_res,
  input  logic             nxt_cf,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_res,
  output logic             out_cf,
  output logic             can_take
);
  // R1: room when empty or when the held result leaves this cycle
  assign can_take = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_res   <= '0;
      out_cf    <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_res   <= nxt_res;
      out_cf    <= nxt_cf;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OP_W-1:0]   in_op,
  input  logic [SZ_W-1:0]   in_size,
  input  logic [DATA_W-1:0] in_dst,
  input  logic [DATA_W-1:0] in_src,
  input  logic [CNT_W-1:0]  in_cnt,
  input  logic              in_cf,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_res,
  output logic              out_cf
);
  amt_t  cnt_eff, rot_amt, rcx_amt;
  logic  cnt_zero;
  word_t nxt_res;
  logic  nxt_cf;
  logic  passthru;
  logic  acc_fire;
  logic  out_fire;

  assign acc_fire = in_valid && in_ready;
  assign out_fire = out_valid && out_ready;

  shrot_count_prep #(.CNT_WIDTH(CNT_W), .MASK_WIDTH(CMASK_W)) cnt_i (
    .cnt      (in_cnt),
    .size     (in_size),
    .cnt_eff  (cnt_eff),
    .cnt_zero (cnt_zero),
    .rot_amt  (rot_amt),
    .rcx_amt  (rcx_amt)
  );

  shrot_datapath dp_i (
    .op       (in_op),
    .size     (in_size),
    .dst      (in_dst),
    .src      (in_src),
    .cf_in    (in_cf),
    .cnt_eff  (cnt_eff),
    .cnt_zero (cnt_zero),
    .rot_amt  (rot_amt),
    .rcx_amt  (rcx_amt),
    .res      (nxt_res),
    .cf_out   (nxt_cf),
    .passthru (passthru)
  );

  shrot_out_stage #(.WIDTH(DATA_W)) out_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (acc_fire),
    .nxt_res   (nxt_res),
    .nxt_cf    (nxt_cf),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_res   (out_res),
    .out_cf    (out_cf),
    .can_take  (in_ready)
  );
endmodule

// File: rtl/shrot_unit_chk.sv
module shrot_unit_chk
  import shrot_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              acc_fire,
  input logic              out_fire,
  input logic              passthru,
  input logic [OP_W-1:0]   in_op,
  input logic [SZ_W-1:0]   in_size,
  input logic [DATA_W-1:0] in_dst,
  input logic [CNT_W-1:0]  in_cnt,
  input logic              in_cf,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_res,
  input logic              out_cf
);
  // R1
  accept_then_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire |=> out_valid);

  // R1
  drain_frees_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fire && !acc_fire) |=> (!out_valid && in_ready));

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_res) && $stable(out_cf)));

  // R3
  zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && in_cnt[CMASK_W-1:0] == '0) |=>
      (out_res == $past(in_dst & size_mask(in_size)) && out_cf == $past(in_cf)));

  // R7
  rol_full_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && in_op == OP_ROL && in_size == SZ_B && in_cnt[CMASK_W-1:0] == 5'd8) |=>
      (out_res == $past(in_dst & DATA_W'(8'hFF))));

  // R11
  byte_zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && in_size == SZ_B) |=> (out_res[DATA_W-1:8] == '0));

  // R11
  keep_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && passthru) |=> (out_cf == $past(in_cf)));
endmodule

bind shrot_unit shrot_unit_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_fire  (acc_fire),
  .out_fire  (out_fire),
  .passthru  (passthru),
  .in_op     (in_op),
  .in_size   (in_size),
  .in_dst    (in_dst),
  .in_cnt    (in_cnt),
  .in_cf     (in_cf),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_res   (out_res),
  .out_cf    (out_cf)
);

// File: tb/shrot_unit_tb_top.sv
module shrot_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_op = '0;
  logic [1:0]  in_size = '0;
  logic [31:0] in_dst = '0;
  logic [31:0] in_src = '0;
  logic [7:0]  in_cnt = '0;
  logic        in_cf = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_res;
  logic        out_cf;

  typedef struct {
    logic [31:0] res;
    logic        cf;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_err = 0;
  bit   done = 1'b0;
  bit   bp_en = 1'b0;

  always #2 clk = ~clk;

  shrot_unit dut_i (
    .clk (clk), .rst_n (rst_n),
    .in_valid (in_valid), .in_ready (in_ready),
    .in_op (in_op), .in_size (in_size), .in_dst (in_dst), .in_src (in_src),
    .in_cnt (in_cnt), .in_cf (in_cf),
    .out_valid (out_valid), .out_ready (out_ready),
    .out_res (out_res), .out_cf (out_cf)
  );

  task automatic chk(input bit ok, input string tag, input logic [32:0] act, input logic [32:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference: repeat a single-position step as many times as the masked count
  function automatic exp_t model(input logic [3:0] op, input logic [1:0] sz,
                                 input logic [31:0] d0, input logic [31:0] s0,
                                 input logic [7:0] cnt, input logic cf0);
    exp_t e;
    int w;
    logic [31:0] m, d, s;
    logic cf, b;
    int n;
    w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    m = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    d = d0 & m;
    s = s0 & m;
    cf = cf0;
    n = int'(cnt & 8'h1F);
    if (op > 4'd8 || (op >= 4'd7 && w == 8)) n = 0;
    for (int i = 0; i < n; i++) begin
      case (op)
        4'd0: begin cf = d[w-1]; d = (d << 1) & m; end
        4'd1: begin cf = d[0]; d = d >> 1; end
        4'd2: begin cf = d[0]; b = d[w-1]; d = (d >> 1) | (32'(b) << (w-1)); end
        4'd3: begin b = d[w-1]; d = ((d << 1) & m) | 32'(b); cf = b; end
        4'd4: begin b = d[0]; d = (d >> 1) | (32'(b) << (w-1)); cf = b; end
        4'd5: begin b = d[w-1]; d = ((d << 1) & m) | 32'(cf); cf = b; end
        4'd6: begin b = d[0]; d = (d >> 1) | (32'(cf) << (w-1)); cf = b; end
        4'd7: begin cf = d[w-1]; d = ((d << 1) & m) | 32'(s[w-1]); s = (s << 1) & m; end
        default: begin cf = d[0]; d = (d >> 1) | (32'(s[0]) << (w-1)); s = s >> 1; end
      endcase
    end
    e.res = d;
    e.cf  = cf;
    if ((cnt & 8'h1F) == 0) e.tag = "R3";
    else if (op > 4'd8 || (op >= 4'd7 && w == 8)) e.tag = "R11";
    else begin
      case (op)
        4'd0: e.tag = "R4";
        4'd1: e.tag = "R5";
        4'd2: e.tag = "R6";
        4'd3, 4'd4: e.tag = "R7";
        4'd5, 4'd6: e.tag = "R8";
        4'd7: e.tag = "R9";
        default: e.tag = "R10";
      endcase
    end
    return e;
  endfunction

  // Driver: called at posedge+1, returns at posedge+1 after acceptance
  task automatic send(input logic [3:0] op, input logic [1:0] sz, input logic [31:0] d,
                      input logic [31:0] s, input logic [7:0] c, input logic cf);
    bit took;
    in_op = op; in_size = sz; in_dst = d; in_src = s; in_cnt = c; in_cf = cf;
    in_valid = 1'b1;
    forever begin
      @(negedge clk);
      took = in_ready;
      @(posedge clk);
      #1;
      if (took) begin
        q.push_back(model(op, sz, d, s, c, cf));
        in_valid = 1'b0;
        chk(out_valid == 1'b1, "R1 result one cycle after accept", 33'(out_valid), 33'd1);
        break;
      end
    end
  endtask

  // Consumer ready pattern
  initial begin
    forever begin
      @(posedge clk);
      #1;
      out_ready = bp_en ? ($urandom_range(0, 2) != 0) : 1'b1;
    end
  end

  // Monitor / scoreboard
  bit          hold_pend = 1'b0;
  logic [31:0] held_res;
  logic        held_cf;
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_pend)
        chk(out_valid && out_res == held_res && out_cf == held_cf, "R2 held while stalled",
            {out_cf, out_res}, {held_cf, held_res});
      hold_pend = out_valid && !out_ready;
      held_res  = out_res;
      held_cf   = out_cf;
      if (out_valid && out_ready) begin
        if (q.size() == 0) begin
          chk(1'b0, "R1 unexpected result", {out_cf, out_res}, 33'd0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(out_res == e.res && out_cf == e.cf, e.tag, {out_cf, out_res}, {e.cf, e.res});
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R1 reset state",
        {31'd0, out_valid, in_ready}, 33'd1);
    @(posedge clk);
    #1;
    // Directed corner cases
    send(4'd7, 2'd2, 32'h0000_3456, 32'h1000_0000, 8'd4, 1'b0);  // R9 worked example
    send(4'd2, 2'd0, 32'h0000_0080, 32'h0, 8'd1, 1'b1);          // R6 8'h80 -> 8'hC0
    send(4'd2, 2'd0, 32'h0000_0091, 32'h0, 8'd12, 1'b0);         // R6 beyond width
    send(4'd3, 2'd0, 32'h0000_00A5, 32'h0, 8'd8, 1'b0);          // R7 full turn byte
    send(4'd4, 2'd1, 32'h0000_8001, 32'h0, 8'd16, 1'b0);         // R7 full turn word
    send(4'd5, 2'd0, 32'h0000_0081, 32'h0, 8'd9, 1'b1);          // R8 modulo 9 -> identity
    send(4'd6, 2'd0, 32'h0000_0003, 32'h0, 8'd20, 1'b0);         // R8 modulo 9 -> 2
    send(4'd0, 2'd0, 32'h0000_00FF, 32'h0, 8'd9, 1'b1);          // R4 beyond width
    send(4'd1, 2'd2, 32'h8000_0001, 32'h0, 8'd1, 1'b0);          // R5
    send(4'd8, 2'd1, 32'h0000_1234, 32'h0000_ABCD, 8'd4, 1'b0);  // R10
    send(4'd0, 2'd2, 32'hDEAD_BEEF, 32'h0, 8'd32, 1'b0);         // R3 masked to zero
    send(4'd3, 2'd0, 32'h0000_0012, 32'h0, 8'h28, 1'b1);         // R3 mask -> 8
    send(4'd7, 2'd0, 32'h0000_0055, 32'hFF, 8'd3, 1'b1);         // R11 byte double shift
    send(4'd13, 2'd2, 32'h1357_9BDF, 32'h0, 8'd5, 1'b0);         // R11 unused opcode
    send(4'd1, 2'd3, 32'hF000_0000, 32'h0, 8'd4, 1'b1);          // R11 size 3 = 32 bits
    // Randomised traffic with back-pressure
    bp_en = 1'b1;
    for (int i = 0; i < 600; i++) begin
      logic [3:0] op;
      op = (i % 13 == 12) ? 4'($urandom_range(9, 15)) : 4'($urandom_range(0, 8));
      send(op, 2'($urandom_range(0, 3)), $urandom, $urandom,
           ((i % 7) == 0) ? 8'($urandom_range(0, 255)) : 8'($urandom_range(0, 33)),
           1'($urandom_range(0, 1)));
    end
    bp_en = 1'b0;
    wait (q.size() == 0);
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL R1 watchdog: actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule